// File: doc/BRIEF.md
# Configuration Start-up Sequencer

This block closes out device configuration. It runs on the configuration clock and watches a raw, active-high reset pin through a short filter made of shift-register stages. A high pulse that lasts only one clock sample is treated as noise. A filtered reset puts the block back into its configuring state. While configuration is in progress, the block holds the user-logic reset high, keeps every output disabled and holds done low.

When the configuration engine reports completion, the sequencer takes two steps, one clock apart. One step releases the internal user reset. The other step turns on the global output enable and raises done. An option bit decides which of the two steps comes first.

On the clock edge where the outputs go live, a global slew-limit override is also asserted. This starts every pad in slow-slew mode and keeps ground bounce low. The override lasts for a programmable number of clock cycles. After that, each pad's own slew setting takes effect again.

Top module: `startup_seq`

## Requirements
- R1: In the cycle after a filtered reset is seen, the outputs show the configuring state: outEnable=0, userRst=1, slewForce=0, done=0.
- R2: A rstPinRaw high level caught by only one rising clock edge has no effect on any output.
- R3: If rstPinRaw is high at two consecutive rising edges, the filtered reset is active after the second edge, and the outputs return to the R1 state at the third edge.
- R4: While cfgComplete stays low in the configuring state, userRst stays 1 and outEnable stays 0.
- R5: With relOrder=0, userRst falls at the first edge that samples cfgComplete=1, and outEnable rises at the next edge.
- R6: With relOrder=1, outEnable rises at the first edge that samples cfgComplete=1, and userRst falls at the next edge.
- R7: done, outEnable and slewForce all rise on the same clock edge.
- R8: slewForce stays high for exactly N cycles. N is softLen sampled on the edge where the outputs go live, and a value of 0 counts as 1. slewForce is never high while outEnable is low.
- R9: Once high, done stays high until a filtered reset. Later changes on cfgComplete are ignored.
- R10: relOrder is captured on the edge that accepts cfgComplete. Changing it afterwards does not change the release order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration clock |
| rstPinRaw | input | 1 | Raw external reset, active high, unfiltered |
| cfgComplete | input | 1 | Configuration data fully loaded |
| relOrder | input | 1 | 0: release reset before outputs go live; 1: release after |
| softLen | input | LEN_W | Soft-start length in clock cycles (0 acts as 1) |
| outEnable | output | 1 | Global output enable |
| userRst | output | 1 | Internal reset to user flip-flops and latches |
| slewForce | output | 1 | Global slow-slew override |
| done | output | 1 | Start-up complete |

## Verification
Some properties are checked on every cycle:
- the state that follows a filtered reset;
- the filtered reset occurring only after two high samples of the pin;
- done, output enable and slew override rising together;
- done being sticky;
- the one-cycle spacing between reset release and output enable in either order.

Other behaviour only the bench scenarios can show:
- that a single-sample spike changes nothing;
- the exact soft-start length, including the zero case;
- that a change of the order bit after acceptance has no effect;
- the abort of a sequence halfway through.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [1:0] {
    SEQ_CFG  = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_LIVE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic abort;   // filtered reset: return outputs to configuring values
    logic clrRst;  // release user reset
    logic setOut;  // enable outputs, raise done, start soft phase
  } seqStrobe_t;

endpackage

// File: rtl/startup_ctrl.sv
module startup_ctrl
  import startup_pkg::*;
(
  input  logic       cfgClk,
  input  logic       rstFilt,
  input  logic       cfgComplete,
  input  logic       relOrder,
  output seqStrobe_t strobe
);

  seqState_t state;
  logic      orderLat;

  always_ff @(posedge cfgClk) begin
    if (rstFilt) begin
      state    <= SEQ_CFG;
      orderLat <= 1'b0;
    end else begin
      case (state)
        SEQ_CFG: begin
          if (cfgComplete) begin
            state    <= SEQ_GAP;
            orderLat <= relOrder;
          end
        end
        SEQ_GAP:  state <= SEQ_LIVE;
        default:  state <= SEQ_LIVE;
      endcase
    end
  end

  logic accept;
  logic second;

  always_comb begin
    accept        = !rstFilt && (state == SEQ_CFG) && cfgComplete;
    second        = !rstFilt && (state == SEQ_GAP);
    strobe.abort  = rstFilt;
    strobe.clrRst = (accept && !relOrder) || (second && orderLat);
    strobe.setOut = (accept && relOrder)  || (second && !orderLat);
  end

endmodule

// File: rtl/startup_dp.sv
module startup_dp
  import startup_pkg::*;
#(
  parameter int FILT_DEPTH = 2,
  parameter int LEN_W      = 8
) (
  input  logic             cfgClk,
  input  logic             rstPinRaw,
  input  logic [LEN_W-1:0] softLen,
  input  seqStrobe_t       strobe,
  output logic             rstFilt,
  output logic             outEnable,
  output logic             userRst,
  output logic             slewForce,
  output logic             done
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  // reset spike filter: all stages must agree
  logic [FILT_DEPTH-1:0] stage;

  for (genvar gi = 0; gi < FILT_DEPTH; gi++) begin : g_filt
    if (gi == 0) begin : g_first
      always_ff @(posedge cfgClk) stage[0] <= rstPinRaw;
    end else begin : g_next
      always_ff @(posedge cfgClk) stage[gi] <= stage[gi-1];
    end
  end

  assign rstFilt = &stage;

  logic [LEN_W-1:0] slewCnt;
  logic [LEN_W-1:0] softLoad;

  assign softLoad = (softLen == '0) ? ONE : softLen;

  always_ff @(posedge cfgClk) begin
    if (strobe.abort) begin
      outEnable <= 1'b0;
      userRst   <= 1'b1;
      slewForce <= 1'b0;
      done      <= 1'b0;
      slewCnt   <= '0;
    end else begin
      if (strobe.setOut) begin
        outEnable <= 1'b1;
        done      <= 1'b1;
        slewForce <= 1'b1;
        slewCnt   <= softLoad;
      end else if (slewForce) begin
        if (slewCnt == ONE) slewForce <= 1'b0;
        slewCnt <= slewCnt - ONE;
      end
      if (strobe.clrRst) userRst <= 1'b0;
    end
  end

endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int FILT_DEPTH = 2,
  parameter int LEN_W      = 8
) (
  input  logic             cfgClk,
  input  logic             rstPinRaw,
  input  logic             cfgComplete,
  input  logic             relOrder,
  input  logic [LEN_W-1:0] softLen,
  output logic             outEnable,
  output logic             userRst,
  output logic             slewForce,
  output logic             done
);

  seqStrobe_t strobe;
  logic       rstFilt;

  startup_ctrl u_ctrl (
    .cfgClk     (cfgClk),
    .rstFilt    (rstFilt),
    .cfgComplete(cfgComplete),
    .relOrder   (relOrder),
    .strobe     (strobe)
  );

  startup_dp #(
    .FILT_DEPTH(FILT_DEPTH),
    .LEN_W     (LEN_W)
  ) u_dp (
    .cfgClk   (cfgClk),
    .rstPinRaw(rstPinRaw),
    .softLen  (softLen),
    .strobe   (strobe),
    .rstFilt  (rstFilt),
    .outEnable(outEnable),
    .userRst  (userRst),
    .slewForce(slewForce),
    .done     (done)
  );

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic cfgClk,
  input logic rstPinRaw,
  input logic rstFilt,
  input logic outEnable,
  input logic userRst,
  input logic slewForce,
  input logic done
);

  logic armed = 1'b0;

  always_ff @(posedge cfgClk) begin
    if (rstFilt) armed <= 1'b1;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge cfgClk) disable iff (!armed)
    rstFilt |=> (!outEnable && userRst && !slewForce && !done));

  // R3
  a_r3_two_samples: assert property (@(posedge cfgClk) disable iff (!armed)
    rstFilt |-> ($past(rstPinRaw) && $past(rstPinRaw, 2)));

  // R5
  a_r5_rst_first: assert property (@(posedge cfgClk) disable iff (!armed || rstFilt)
    ($fell(userRst) && !outEnable) |=> $rose(outEnable));

  // R6
  a_r6_out_first: assert property (@(posedge cfgClk) disable iff (!armed || rstFilt)
    ($rose(outEnable) && userRst) |=> $fell(userRst));

  // R7
  a_r7_together: assert property (@(posedge cfgClk) disable iff (!armed)
    $rose(outEnable) |-> (done && slewForce));

  // R8
  a_r8_slew_needs_out: assert property (@(posedge cfgClk) disable iff (!armed)
    slewForce |-> outEnable);

  // R9
  a_r9_done_sticky: assert property (@(posedge cfgClk) disable iff (!armed || rstFilt)
    done |=> done);

endmodule

bind startup_seq startup_seq_chk u_chk (
  .cfgClk   (cfgClk),
  .rstPinRaw(rstPinRaw),
  .rstFilt  (rstFilt),
  .outEnable(outEnable),
  .userRst  (userRst),
  .slewForce(slewForce),
  .done     (done)
);

// File: tb/startup_seq_bench.sv
module startup_seq_bench;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rstPinRaw = 1'b1;
  logic             cfgComplete = 1'b0;
  logic             relOrder = 1'b0;
  logic [LEN_W-1:0] softLen = '0;
  logic             outEnable, userRst, slewForce, done;

  always #4 clk = ~clk;

  startup_seq #(.FILT_DEPTH(2), .LEN_W(LEN_W)) u_startup_seq (
    .cfgClk     (clk),
    .rstPinRaw  (rstPinRaw),
    .cfgComplete(cfgComplete),
    .relOrder   (relOrder),
    .softLen    (softLen),
    .outEnable  (outEnable),
    .userRst    (userRst),
    .slewForce  (slewForce),
    .done       (done)
  );

  int    checks = 0;
  int    fails = 0;
  bit    cmpOn = 0;
  bit    finished = 0;
  string curReq = "R1";

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int  samp[$];
  int  phase = 0;
  bit  optM = 0;
  int  slewLeft = 0;
  bit  mOut = 0, mRst = 1, mSlew = 0, mDone = 0;

  initial begin
    samp.push_back(0);
    samp.push_back(0);
  end

  always @(posedge clk) begin
    bit filtNow;
    filtNow = (samp[0] != 0) && (samp[1] != 0);
    void'(samp.pop_back());
    samp.push_front(int'(rstPinRaw));
    if (filtNow) begin
      phase = 0; mOut = 0; mRst = 1; mSlew = 0; mDone = 0; slewLeft = 0;
    end else begin
      if (mSlew) begin
        slewLeft = slewLeft - 1;
        if (slewLeft == 0) mSlew = 0;
      end
      if (phase == 0 && cfgComplete) begin
        optM  = relOrder;
        phase = 1;
        if (optM) begin
          mOut = 1; mDone = 1; mSlew = 1;
          slewLeft = (softLen == 0) ? 1 : int'(softLen);
        end else mRst = 0;
      end else if (phase == 1) begin
        phase = 2;
        if (optM) mRst = 0;
        else begin
          mOut = 1; mDone = 1; mSlew = 1;
          slewLeft = (softLen == 0) ? 1 : int'(softLen);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      chk(curReq, "model outEnable", outEnable, mOut);
      chk(curReq, "model userRst", userRst, mRst);
      chk(curReq, "model slewForce", slewForce, mSlew);
      chk(curReq, "model done", done, mDone);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int cnt;
    // R1: power-up reset through the filter
    step(4);
    rstPinRaw = 1'b0;
    cmpOn = 1;
    chk("R1", "outEnable", outEnable, 1'b0);
    chk("R1", "userRst", userRst, 1'b1);
    chk("R1", "done", done, 1'b0);

    // R4: configuring
    curReq = "R4";
    step(5);
    chk("R4", "userRst", userRst, 1'b1);
    chk("R4", "outEnable", outEnable, 1'b0);

    // R5, R7, R8: reset first, soft start of 3
    curReq = "R5";
    relOrder = 1'b0; softLen = 8'd3; cfgComplete = 1'b1;
    step(1);
    cfgComplete = 1'b0;
    chk("R5", "userRst", userRst, 1'b0);
    chk("R5", "outEnable", outEnable, 1'b0);
    step(1);
    chk("R7", "outEnable", outEnable, 1'b1);
    chk("R7", "done", done, 1'b1);
    chk("R7", "slewForce", slewForce, 1'b1);
    curReq = "R8";
    cnt = 0;
    while (slewForce && cnt < 300) begin cnt++; step(1); end
    checks++;
    if (cnt != 3) begin fails++; $display("FAIL R8 slew cycles actual=%0d expected=3", cnt); end

    // R2: one-sample spike ignored
    curReq = "R2";
    rstPinRaw = 1'b1; step(1); rstPinRaw = 1'b0;
    step(3);
    chk("R2", "done", done, 1'b1);
    chk("R2", "outEnable", outEnable, 1'b1);
    chk("R2", "userRst", userRst, 1'b0);

    // R9: cfgComplete and relOrder changes ignored when live
    curReq = "R9";
    cfgComplete = 1'b1; relOrder = 1'b1; step(3);
    cfgComplete = 1'b0; step(2);
    chk("R9", "done", done, 1'b1);
    chk("R9", "outEnable", outEnable, 1'b1);

    // R3: two-sample reset
    curReq = "R3";
    rstPinRaw = 1'b1; step(2);
    chk("R3", "done before abort", done, 1'b1);
    rstPinRaw = 1'b0; step(1);
    chk("R3", "done", done, 1'b0);
    chk("R3", "userRst", userRst, 1'b1);
    chk("R3", "outEnable", outEnable, 1'b0);
    step(3);

    // R6, R10, R8 boundary: outputs first, softLen 0
    curReq = "R6";
    relOrder = 1'b1; softLen = 8'd0; cfgComplete = 1'b1;
    step(1);
    relOrder = 1'b0; cfgComplete = 1'b0;
    chk("R6", "outEnable", outEnable, 1'b1);
    chk("R6", "userRst", userRst, 1'b1);
    chk("R8", "slewForce zero length", slewForce, 1'b1);
    step(1);
    chk("R10", "userRst", userRst, 1'b0);
    chk("R8", "slewForce after one", slewForce, 1'b0);
    step(4);

    // abort in the middle of the sequence
    curReq = "R3";
    rstPinRaw = 1'b1; step(3); rstPinRaw = 1'b0; step(3);
    relOrder = 1'b0; softLen = 8'd7; cfgComplete = 1'b1; step(1);
    cfgComplete = 1'b0; rstPinRaw = 1'b1; step(2); rstPinRaw = 1'b0; step(1);
    chk("R1", "outEnable after abort", outEnable, 1'b0);
    chk("R1", "userRst after abort", userRst, 1'b1);
    step(3);

    // long soft start, cfgComplete held
    curReq = "R8";
    relOrder = 1'b1; softLen = 8'd200; cfgComplete = 1'b1;
    step(1);
    cnt = 0;
    while (slewForce && cnt < 300) begin cnt++; step(1); end
    checks++;
    if (cnt != 200) begin fails++; $display("FAIL R8 slew cycles actual=%0d expected=200", cnt); end
    chk("R9", "done held", done, 1'b1);
    step(3);
    summary();
  end

endmodule